// File: doc/BRIEF.md
# Incremental One's Complement Checksum Updater

This block keeps the per-device checksums of a group of memory lines up to date without rereading the group. A checksum line holds one one's complement checksum for each symbol position (device) of a codeword. Each such checksum sums the symbols that one device holds across the lines of its group. The block takes a checksum line and one data codeword. It returns a new checksum line with that codeword's contribution either removed or added. Every symbol position is handled by its own lane, and no lane sees any other lane.

The surrounding cache controller uses it in two steps. The first time a clean line is modified, it issues a subtract with the line's old (clean) data, which removes the old contribution. When the dirty line is later written back, it issues an add with the new data. Subtracting a value is done by adding its bitwise complement with end-around carry. Because of this, the all-zeros and all-ones codes both stand for zero, and any comparison of checksums must treat them as equal. The block is a single registered stage: a request presented with the input strobe gives its result one clock later.

Top module: `ocs_line_upd`

## Requirements
- R1: While reset is asserted, and after it until the first accepted request, `out_valid` is 0 and `out_csum` is all zeros.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` = 1, and 0 after a cycle with `in_valid` = 0.
- R3: With `in_op` = 0 (add), each lane's result is congruent to checksum + data modulo 2^SYM_W − 1, computed with end-around carry. It is all zeros only when both the checksum symbol and the data symbol are all zeros; otherwise it lies in 1 .. 2^SYM_W − 1.
- R4: With `in_op` = 1 (subtract), each lane adds the bitwise complement of its data symbol with end-around carry. The result is congruent to checksum − data modulo 2^SYM_W − 1 and follows the same zero rule as R3 applied to the complemented operand. Subtracting an all-ones data symbol returns the checksum symbol unchanged.
- R5: Lane k (bits k*SYM_W and up) depends only on lane k of `in_csum` and `in_data`. A change in another lane's data leaves it unaffected.
- R6: When `in_valid` is 0, `out_csum` keeps its value, whatever the other inputs do.
- R7: Subtracting a data value and then adding the same value gives back the original checksum, where all-zeros and all-ones count as the same value.
- R8: Adding an all-zeros data symbol returns the checksum symbol bit-exact. Subtracting an all-zeros data symbol also returns it bit-exact, except that an all-zeros checksum comes back as all-ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| in_valid | input | 1 | Request strobe; the inputs are taken when it is 1 |
| in_op | input | 1 | 0 = add the data contribution, 1 = subtract it |
| in_csum | input | NUM_DEV*SYM_W | Current checksum line, lane k at bits [k*SYM_W +: SYM_W] |
| in_data | input | NUM_DEV*SYM_W | Data codeword, one symbol per lane, same lane order |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_csum | output | NUM_DEV*SYM_W | Updated checksum line |

## Verification
The bench builds the block with SYM_W = 4 and NUM_DEV = 3. At that width every checksum and data pair, 256 of them for each operation, can be swept exhaustively. So every end-around-carry case is reached, including the 0/all-ones double zero, as are the subtract-then-add round trip for all pairs and the identity cases of R8. Three lanes are enough to drive different operands into neighbouring lanes at the same time and to show that a lane is blind to the others.

// File: rtl/ocs_pkg.sv
package ocs_pkg;

  typedef enum logic {
    OCS_ADD = 1'b0,
    OCS_SUB = 1'b1
  } ocs_op_e;

endpackage

// File: rtl/ocs_lane.sv
// One symbol position: one's complement add or subtract with end-around carry.
module ocs_lane #(
  parameter int SYM_W = 16
) (
  input  ocs_pkg::ocs_op_e  op,
  input  logic [SYM_W-1:0]  csum,
  input  logic [SYM_W-1:0]  data,
  output logic [SYM_W-1:0]  sum
);

  logic [SYM_W-1:0] operand;
  logic [SYM_W:0]   wide;

  always_comb begin
    operand = (op == ocs_pkg::OCS_SUB) ? ~data : data;
    wide    = {1'b0, csum} + {1'b0, operand};
    // Folding the carry back in cannot overflow: the largest wide value is 2^(W+1)-2.
    sum     = wide[SYM_W-1:0] + {{(SYM_W-1){1'b0}}, wide[SYM_W]};
  end

endmodule

// File: rtl/ocs_stage.sv
// Enabled register stage, reset to zero.
module ocs_stage #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/ocs_line_upd.sv
module ocs_line_upd #(
  parameter int SYM_W   = 16,
  parameter int NUM_DEV = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       in_op,
  input  logic [NUM_DEV*SYM_W-1:0]   in_csum,
  input  logic [NUM_DEV*SYM_W-1:0]   in_data,
  output logic                       out_valid,
  output logic [NUM_DEV*SYM_W-1:0]   out_csum
);

  localparam int LINE_W = NUM_DEV * SYM_W;

  ocs_pkg::ocs_op_e    op;
  logic [LINE_W-1:0]   sum_nxt;
  logic                vld_nxt;

  always_comb op = ocs_pkg::ocs_op_e'(in_op);

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_lane
    ocs_lane #(.SYM_W(SYM_W)) u_lane (
      .op   (op),
      .csum (in_csum[k*SYM_W +: SYM_W]),
      .data (in_data[k*SYM_W +: SYM_W]),
      .sum  (sum_nxt[k*SYM_W +: SYM_W])
    );
  end

  ocs_stage #(.WIDTH(LINE_W)) u_csum_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (in_valid),
    .d     (sum_nxt),
    .q     (out_csum)
  );

  always_comb vld_nxt = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= vld_nxt;
  end

endmodule

// File: rtl/ocs_line_upd_chk.sv
module ocs_line_upd_chk #(
  parameter int SYM_W   = 16,
  parameter int NUM_DEV = 9
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_op,
  input logic [NUM_DEV*SYM_W-1:0] in_csum,
  input logic [NUM_DEV*SYM_W-1:0] in_data,
  input logic                     out_valid,
  input logic [NUM_DEV*SYM_W-1:0] out_csum
);

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_clear_chk: assert (!out_valid && out_csum == '0)
        else $error("outputs not cleared in reset");
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_csum));

  // R8
  add_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_op && in_data == '0) |=> out_csum == $past(in_csum));

  // R4
  sub_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op && in_data == '1) |=> out_csum == $past(in_csum));

  // R3
  zero_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_op && in_csum == '0 && in_data == '0) |=> out_csum == '0);

endmodule

bind ocs_line_upd ocs_line_upd_chk #(.SYM_W(SYM_W), .NUM_DEV(NUM_DEV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .in_csum   (in_csum),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_csum  (out_csum)
);

// File: tb/ocs_line_upd_test.sv
`timescale 1ns/1ps
module ocs_line_upd_test;

  localparam int W = 4;
  localparam int L = 3;
  localparam int M = (1 << W) - 1;

  logic           clk;
  logic           rst_n;
  logic           in_valid;
  logic           in_op;
  logic [L*W-1:0] in_csum;
  logic [L*W-1:0] in_data;
  logic           out_valid;
  logic [L*W-1:0] out_csum;

  int n_chk;
  int n_fail;

  ocs_line_upd #(.SYM_W(W), .NUM_DEV(L)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_csum(in_csum), .in_data(in_data), .out_valid(out_valid), .out_csum(out_csum)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Residue arithmetic: 0 only for 0+0, otherwise a value in 1..M.
  function automatic int ref_lane(int c, int d, bit sub);
    int opnd;
    int t;
    opnd = sub ? (M - d) : d;
    t = c + opnd;
    if (t == 0) return 0;
    return ((t - 1) % M) + 1;
  endfunction

  function automatic int lane_of(logic [L*W-1:0] v, int k);
    return int'((v >> (k * W)) & M);
  endfunction

  function automatic logic [L*W-1:0] pack3(int a, int b, int c);
    return {c[W-1:0], b[W-1:0], a[W-1:0]};
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Present one request, return sampled at the next falling edge.
  task automatic apply(bit op, logic [L*W-1:0] c, logic [L*W-1:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    in_csum  = c;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_op = 1'b0;
    in_csum = '0;
    in_data = '0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset csum", int'(out_csum), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 post-reset valid", int'(out_valid), 0);
    check("R1 post-reset csum", int'(out_csum), 0);

    // R3 / R4: exhaustive pairs, different operand mixes per lane
    for (int op = 0; op < 2; op++) begin
      for (int c = 0; c <= M; c++) begin
        for (int d = 0; d <= M; d++) begin
          int c2;
          int d2;
          c2 = c ^ d;
          d2 = M - d;
          apply(bit'(op), pack3(c, d, c2), pack3(d, c, d2));
          check(op ? "R4 lane0" : "R3 lane0", lane_of(out_csum, 0), ref_lane(c, d, bit'(op)));
          check(op ? "R4 lane1" : "R3 lane1", lane_of(out_csum, 1), ref_lane(d, c, bit'(op)));
          check(op ? "R4 lane2" : "R3 lane2", lane_of(out_csum, 2), ref_lane(c2, d2, bit'(op)));
          check("R2 valid high", int'(out_valid), 1);
        end
      end
    end

    // R2: valid drops one cycle after the strobe drops
    @(negedge clk);
    check("R2 valid low", int'(out_valid), 0);

    // R7: subtract then add same data returns the checksum modulo +/-0
    for (int c = 0; c <= M; c++) begin
      for (int d = 0; d <= M; d++) begin
        logic [L*W-1:0] mid;
        apply(1'b1, pack3(c, c, c), pack3(d, M - d, d));
        mid = out_csum;
        apply(1'b0, mid, pack3(d, M - d, d));
        for (int k = 0; k < L; k++) begin
          check("R7 roundtrip", lane_of(out_csum, k) % M, c % M);
        end
      end
    end

    // R8: zero data identities
    for (int c = 0; c <= M; c++) begin
      apply(1'b0, pack3(c, c, c), '0);
      check("R8 add zero", lane_of(out_csum, 1), c);
      apply(1'b1, pack3(c, c, c), '0);
      check("R8 sub zero", lane_of(out_csum, 2), (c == 0) ? M : c);
    end

    // R5: data in lane 1 only, lanes 0 and 2 stay at their checksum
    for (int d = 1; d <= M; d++) begin
      apply(1'b0, pack3(5, 6, 9), pack3(0, d, 0));
      check("R5 lane0 untouched", lane_of(out_csum, 0), 5);
      check("R5 lane2 untouched", lane_of(out_csum, 2), 9);
      check("R5 lane1 updated", lane_of(out_csum, 1), ref_lane(6, d, 1'b0));
    end

    // R6: idle cycles with changing inputs leave the result alone
    apply(1'b0, pack3(3, 4, 7), pack3(2, 2, 2));
    begin
      logic [L*W-1:0] held;
      held = out_csum;
      for (int i = 0; i < 6; i++) begin
        in_op   = i[0];
        in_csum = pack3(i, i + 1, i + 2);
        in_data = pack3(M - i, i, 1);
        @(negedge clk);
        check("R6 hold csum", int'(out_csum), int'(held));
        check("R6 hold valid", int'(out_valid), 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule